// File: doc/BRIEF.md
# Input Edge Calibration Sampler

This block measures where a transition on one chosen interface input lands inside the divided core-clock period. It runs on the fast source clock. A free-running phase index counts source-clock cycles within each core-clock period. When calibration is armed, the block records the phase index of the first transition of the chosen polarity on the selected input and raises a valid flag. Software or a tuning engine can then move a sampling point or a delay setting toward the middle of the data eye.

The ten inputs are eight data lines, the command line and the data strobe. They are synchronized before any use. The same synchronized inputs are also offered to the downstream logic in one of two ways. They can pass straight through, or they can be resampled once per core-clock period at a chosen phase index, so that the receive path sees values taken at a fixed point of the period.

A registered copy of the calibration setup is returned beside the result. A reader of the result can then see which configuration produced it.

Top module: `edge_cal_sampler`

## Requirements
- R1: The phase index is 0 after reset and increases by one each source clock. After it reaches `period_div`-1 it returns to 0. When `period_div` is 0 or 1 the index stays at 0. The index is seen through `cal_index`.
- R2: While reset is asserted, `cal_index`, `cal_valid`, `setup_echo` and `lines_out` are all zero.
- R3: `cal_sel` picks the observed line. Values 0 to 7 select `lines_in[0]` to `lines_in[7]` (data), 8 selects `lines_in[8]` (command) and 9 selects `lines_in[9]` (strobe). Values 10 to 15 never produce a capture, and transitions on unselected lines never produce a capture.
- R4: When `cal_rising` is 1, only a 0-to-1 transition is captured. When it is 0, only a 1-to-0 transition is captured. A transition of the other polarity is ignored.
- R5: Suppose the selected input changes between clock edges k-1 and k. Then `cal_index` takes the phase index held after edge k+1, and `cal_valid` rises after edge k+2.
- R6: Once a reading is valid, later transitions leave `cal_index` and `cal_valid` unchanged until calibration is re-armed.
- R7: A 0-to-1 change of `cal_enable` clears `cal_valid` at the next edge and arms a new capture. While `cal_enable` is 0, no capture happens and the last reading is held.
- R8: One edge after the inputs, `setup_echo` equals {1'b0, `cal_rising`, `adj_enable`, `cal_enable`, `cal_sel`[3:0]}, with `cal_sel` in bits 3:0.
- R9: With `adj_enable` at 0, `lines_out` equals `lines_in` delayed by two clock edges.
- R10: A resample register captures the two-edge-delayed inputs at every edge that ends a cycle whose phase index equals `adj_index`. It captures whether or not adjust is enabled. With `adj_enable` at 1, `lines_out` shows this register. If `adj_index` is never reached, the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| period_div | input | 6 | Source cycles per core-clock period |
| lines_in | input | 10 | Data lines 0-7, command line 8, strobe 9 |
| cal_sel | input | 4 | Selected line for calibration |
| cal_enable | input | 1 | Calibration enable; its rising edge arms a capture |
| cal_rising | input | 1 | 1: capture rising transition, 0: falling |
| adj_enable | input | 1 | Route resampled values to lines_out |
| adj_index | input | 6 | Phase index at which inputs are resampled |
| cal_index | output | 6 | Captured phase index |
| cal_valid | output | 1 | Captured index is valid |
| setup_echo | output | 8 | Registered copy of the calibration setup |
| lines_out | output | 10 | Synchronized or resampled inputs |

## Verification
The hardest situation to reach from the ports is a capture at a specific, known phase index. The phase counter is hidden, and every transition passes through two synchronizer stages before it is seen. The bench keeps an arithmetic model of the phase index. It launches the selected transition after a swept number of idle cycles and reads the expected index two edges later. Each armed run first applies the opposite-polarity transition and a matching transition on a neighbouring line. In this way the rejection paths are exercised before the real capture.

// File: rtl/edge_cal_pkg.sv
package edge_cal_pkg;
  localparam int unsigned CAL_NUM_LINES = 10;
  localparam int unsigned CAL_IDX_W     = 6;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_DONE  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i[b]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '0;
        end else begin
          chain_q <= chain_d;
        end
      end

      assign q_o[b] = chain_q[LAST];
    end
  endgenerate
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] div_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             at_end;

  always_comb begin
    at_end = (div_i <= ONE) || (idx_q >= (div_i - ONE));
    if (at_end) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;

  assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i > ONE) |=> (idx_q < $past(div_i)))
    else $error("phase index beyond period");

  assert_idx_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_i > ONE) && (idx_q == div_i - ONE)) |=> (idx_q == '0))
    else $error("phase index did not wrap");

  assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i <= ONE) |=> (idx_q == '0))
    else $error("phase index moved with trivial divisor");
endmodule

// File: rtl/edge_capture.sv
module edge_capture
  import edge_cal_pkg::*;
#(
  parameter int unsigned NLINES = 10,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] sync_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  input  edge_pol_e         pol_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [IDX_W-1:0]  cap_idx_o,
  output logic              cap_vld_o
);
  localparam logic [SEL_W:0] NLINES_L = (SEL_W+1)'(NLINES);

  logic [NLINES-1:0] prev_q;
  logic              en_d_q;
  cap_state_e        state_q, state_d;
  logic [IDX_W-1:0]  cap_idx_q, cap_idx_d;
  logic              cap_vld_q, cap_vld_d;

  logic sel_ok;
  logic cur_bit;
  logic old_bit;
  logic hit;
  logic arm_rise;

  always_comb begin
    cur_bit = 1'b0;
    old_bit = 1'b0;
    for (int i = 0; i < int'(NLINES); i++) begin
      if (sel_i == SEL_W'(i)) begin
        cur_bit = sync_i[i];
        old_bit = prev_q[i];
      end
    end
  end

  always_comb begin
    sel_ok   = ({1'b0, sel_i} < NLINES_L);
    arm_rise = en_i && !en_d_q;
    if (pol_i == POL_RISE) begin
      hit = sel_ok && cur_bit && !old_bit;
    end else begin
      hit = sel_ok && !cur_bit && old_bit;
    end
  end

  always_comb begin
    state_d   = state_q;
    cap_idx_d = cap_idx_q;
    cap_vld_d = cap_vld_q;
    if (!en_i) begin
      state_d = CAP_IDLE;
    end else if (arm_rise) begin
      state_d   = CAP_ARMED;
      cap_vld_d = 1'b0;
    end else if ((state_q == CAP_ARMED) && hit) begin
      state_d   = CAP_DONE;
      cap_idx_d = idx_i;
      cap_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      en_d_q    <= 1'b0;
      state_q   <= CAP_IDLE;
      cap_idx_q <= '0;
      cap_vld_q <= 1'b0;
    end else begin
      prev_q    <= sync_i;
      en_d_q    <= en_i;
      state_q   <= state_d;
      cap_idx_q <= cap_idx_d;
      cap_vld_q <= cap_vld_d;
    end
  end

  assign cap_idx_o = cap_idx_q;
  assign cap_vld_o = cap_vld_q;

  assert_first_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld_q && !arm_rise) |=> (cap_vld_q && $stable(cap_idx_q)))
    else $error("reading changed after first capture");

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(cap_idx_q) && $stable(cap_vld_q)))
    else $error("reading changed while disabled");

  assert_rearm_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_rise |=> !cap_vld_q)
    else $error("re-arm did not clear valid");

  assert_bad_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !$rose(cap_vld_q))
    else $error("capture with out-of-range select");
endmodule

// File: rtl/line_resampler.sv
module line_resampler #(
  parameter int unsigned NLINES = 10,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] sync_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              adj_en_i,
  input  logic [IDX_W-1:0]  adj_idx_i,
  output logic [NLINES-1:0] lines_o
);
  logic [NLINES-1:0] hold_q, hold_d;
  logic              take;

  always_comb begin
    take   = (idx_i == adj_idx_i);
    hold_d = take ? sync_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  always_comb begin
    if (adj_en_i) begin
      lines_o = hold_q;
    end else begin
      lines_o = sync_i;
    end
  end

  assert_sample_only_at_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_i != adj_idx_i) |=> $stable(hold_q))
    else $error("resample register changed off index");
endmodule

// File: rtl/edge_cal_sampler.sv
module edge_cal_sampler
  import edge_cal_pkg::*;
#(
  parameter int unsigned NLINES = CAL_NUM_LINES,
  parameter int unsigned IDX_W  = CAL_IDX_W,
  localparam int unsigned SEL_W = $clog2(NLINES),
  localparam int unsigned SET_W = SEL_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  period_div,
  input  logic [NLINES-1:0] lines_in,
  input  logic [SEL_W-1:0]  cal_sel,
  input  logic              cal_enable,
  input  logic              cal_rising,
  input  logic              adj_enable,
  input  logic [IDX_W-1:0]  adj_index,
  output logic [IDX_W-1:0]  cal_index,
  output logic              cal_valid,
  output logic [SET_W-1:0]  setup_echo,
  output logic [NLINES-1:0] lines_out
);
  logic [NLINES-1:0] sync_lines;
  logic [IDX_W-1:0]  phase_idx;
  logic [SET_W-1:0]  echo_q, echo_d;
  edge_pol_e         pol;

  assign pol = cal_rising ? POL_RISE : POL_FALL;

  line_sync #(.W(NLINES), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lines_in),
    .q_o   (sync_lines)
  );

  phase_counter #(.IDX_W(IDX_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .div_i (period_div),
    .idx_o (phase_idx)
  );

  edge_capture #(.NLINES(NLINES), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_lines),
    .sel_i     (cal_sel),
    .en_i      (cal_enable),
    .pol_i     (pol),
    .idx_i     (phase_idx),
    .cap_idx_o (cal_index),
    .cap_vld_o (cal_valid)
  );

  line_resampler #(.NLINES(NLINES), .IDX_W(IDX_W)) u_resamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_lines),
    .idx_i     (phase_idx),
    .adj_en_i  (adj_enable),
    .adj_idx_i (adj_index),
    .lines_o   (lines_out)
  );

  always_comb begin
    echo_d = {1'b0, cal_rising, adj_enable, cal_enable, cal_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q <= '0;
    end else begin
      echo_q <= echo_d;
    end
  end

  assign setup_echo = echo_q;

  assert_echo_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (setup_echo[3:0] == $past(cal_sel) && setup_echo[4] == $past(cal_enable)
              && setup_echo[6] == $past(cal_rising) && !setup_echo[7]))
    else $error("setup echo mismatch");
endmodule

// File: tb/tb_edge_cal_sampler.sv
module tb_edge_cal_sampler;
  logic       clk;
  logic       rst_n;
  logic [5:0] period_div;
  logic [9:0] lines_in;
  logic [3:0] cal_sel;
  logic       cal_enable;
  logic       cal_rising;
  logic       adj_enable;
  logic [5:0] adj_index;
  logic [5:0] cal_index;
  logic       cal_valid;
  logic [7:0] setup_echo;
  logic [9:0] lines_out;

  int vectors;
  int fails;
  logic [15:0] lfsr;

  // requirement models: phase index (R1), two-edge delay (R9), resample register (R10)
  logic [5:0] m_idx;
  logic [9:0] m_d1, m_d2, m_hold;

  edge_cal_sampler dut (
    .clk(clk), .rst_n(rst_n), .period_div(period_div), .lines_in(lines_in),
    .cal_sel(cal_sel), .cal_enable(cal_enable), .cal_rising(cal_rising),
    .adj_enable(adj_enable), .adj_index(adj_index), .cal_index(cal_index),
    .cal_valid(cal_valid), .setup_echo(setup_echo), .lines_out(lines_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx <= '0; m_d1 <= '0; m_d2 <= '0; m_hold <= '0;
    end else begin
      m_d1 <= lines_in;
      m_d2 <= m_d1;
      if (m_idx == adj_index) m_hold <= m_d2;
      if (period_div <= 6'd1 || m_idx >= period_div - 6'd1) m_idx <= '0;
      else m_idx <= m_idx + 6'd1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_cap(input int d, input int s, input bit r, input int ph);
    int o;
    int exp_idx;
    o = (s < 10) ? ((s + 1) % 10) : 0;
    @(negedge clk);
    period_div = 6'(d); cal_enable = 1'b0; cal_sel = 4'(s); cal_rising = r;
    lines_in = r ? 10'h3ff : 10'h000;
    lines_in[o] = !r;
    idle(4);
    check(setup_echo == {1'b0, r, adj_enable, 1'b0, 4'(s)}, "R8", setup_echo,
          {1'b0, r, adj_enable, 1'b0, 4'(s)});
    cal_enable = 1'b1;
    @(negedge clk);
    check(cal_valid == 1'b0, "R7 clear", cal_valid, 0);
    check(setup_echo[4] == 1'b1, "R8 enable", setup_echo[4], 1);
    idle(3 + ph);
    if (s < 10) lines_in[s] = !r;
    lines_in[o] = r;
    idle(5);
    check(cal_valid == 1'b0, "R3 R4 rejected", cal_valid, 0);
    if (s >= 10) begin
      lines_in = ~lines_in; idle(4);
      lines_in = ~lines_in; idle(4);
      check(cal_valid == 1'b0, "R3 bad select", cal_valid, 0);
      cal_enable = 1'b0;
      return;
    end
    lines_in[s] = r;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_idx = int'(m_idx);
    check(cal_valid == 1'b0, "R5 latency", cal_valid, 0);
    @(negedge clk);
    check(cal_valid == 1'b1, "R5 valid", cal_valid, 1);
    check(int'(cal_index) == exp_idx, "R5 R1 index", cal_index, exp_idx);
    lines_in[s] = !r; idle(3);
    lines_in[s] = r; idle(4);
    check(cal_valid && int'(cal_index) == exp_idx, "R6 first only", cal_index, exp_idx);
    cal_enable = 1'b0; idle(2);
    lines_in[s] = !r; idle(3);
    lines_in[s] = r; idle(4);
    check(cal_valid && int'(cal_index) == exp_idx, "R7 hold disabled", cal_index, exp_idx);
  endtask

  task automatic run_adj(input int d, input int a, input bit en);
    @(negedge clk);
    period_div = 6'(d); adj_index = 6'(a); adj_enable = en; cal_enable = 1'b0;
    for (int i = 0; i < 3 * d + 8; i++) begin
      @(negedge clk);
      if (en) check(lines_out == m_hold, "R10 resample", lines_out, m_hold);
      else    check(lines_out == m_d2, "R9 bypass", lines_out, m_d2);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lines_in = lfsr[9:0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int dv[4];
    vectors = 0; fails = 0; lfsr = 16'hace1;
    dv[0] = 1; dv[1] = 3; dv[2] = 7; dv[3] = 12;
    rst_n = 1'b0; period_div = 6'd4; lines_in = 10'h2a5; cal_sel = 4'd3;
    cal_enable = 1'b1; cal_rising = 1'b1; adj_enable = 1'b0; adj_index = 6'd0;
    idle(3);
    check(cal_index == 6'd0 && cal_valid == 1'b0, "R2 result", {cal_valid, cal_index}, 0);
    check(setup_echo == 8'd0 && lines_out == 10'd0, "R2 echo lines", {setup_echo, lines_out}, 0);
    rst_n = 1'b1;
    cal_enable = 1'b0;
    idle(3);
    for (int di = 0; di < 4; di++)
      for (int s = 0; s < 16; s++)
        for (int r = 0; r < 2; r++)
          for (int ph = 0; ph < 3; ph++)
            run_cap(dv[di], s, r[0], ph + (s % 4) * 3);
    for (int d = 1; d < 12; d += 3)
      for (int a = 0; a < 10; a++)
        for (int e = 0; e < 2; e++)
          run_adj(d, a, e[0]);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule